// File: doc/BRIEF.md
# Split-Operand Crosswise Multiplier

This block multiplies two unsigned 32-bit operands and returns their full 64-bit product. It contains no registers: the product follows the operands through combinational logic alone, and the design aims at a short input-to-output path. A surrounding pipeline that needs a registered product adds its own flops around the block.

Each operand is cut into a high and a low 16-bit half, and the four 16x16 sub-products are formed in the vertical and crosswise pattern. The vertical products are low times low and high times high. The crosswise products are high times low and low times high. The two vertical products cannot overlap, so together they fill a single 64-bit row, with high times high on top. Each crosswise product, moved up by 16 bits, forms one more row. One carry-save stage compresses the three rows into a sum vector and a carry vector. One carry-propagate addition then merges the two vectors into the product.

Each 16x16 sub-multiplier is built with the same split, one level inside the next. The split goes down through 8-bit and 4-bit nodes to 2x2 cells, and each 2x2 cell combines its bits in the crosswise way.

Top module: `xw_mul32`

## Requirements
- R1: `product` equals the exact unsigned product `op_a * op_b`, as 64 bits, for every pair of 32-bit operands.
- R2: When either operand is zero, `product` is zero, whatever the other operand holds.
- R3: When one operand equals 1, `product` equals the other operand, zero-extended to 64 bits.
- R4: All-ones times all-ones (0xFFFFFFFF by 0xFFFFFFFF) gives 0xFFFFFFFE00000001. No carry is lost from the final addition at that extreme.
- R5: If `op_a` = 2^i and `op_b` = 2^j, with i and j from 0 to 31, `product` = 2^(i+j). Only bit i+j of `product` is set.
- R6: Operands that are non-zero in one 16-bit half only are placed at the right weight. High half times high half lands in bits 63:32. Low half times low half lands in bits 31:0. A high half times a low half lands at a shift of 16 bits.
- R7: The three partial-product rows are reduced by exactly one carry-save stage. The stage's sum plus twice its carry equals the sum of the three rows. The carry vector's top bit is zero, and the final addition produces no carry out of bit 63.
- R8: The block is purely combinational. `product` reflects new operands in the same time step, without any clock edge.
- R9: Every 2x2 leaf cell yields the exact 4-bit product of its two 2-bit inputs. Operands below 4 therefore give products equal to the small-number multiplication table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Unsigned multiplicand |
| op_b | input | 32 | Unsigned multiplier |
| product | output | 64 | Unsigned full-width product of op_a and op_b |

## Verification
The hardest condition to reach from the ports is a long carry chain through the single carry-save stage. A long chain needs the vertical row and both crosswise rows to hold ones at the same weights at the same time, and random operands seldom produce that. The stimulus therefore mixes fixed corner operands with random pairs. The corner operands are all-ones, half-all-ones, alternating bit patterns and values near the 16-bit boundary, and they drive carries across the 16-bit and 32-bit seams. Random pairs with one half forced to all-ones or to zero keep the crosswise rows dense or empty while the other half varies.

// File: rtl/xw_mul_pkg.sv
// Package: shared constants and helpers for the crosswise multiplier tree.
// Assumes operand widths are powers of two, no smaller than the leaf width.
package xw_mul_pkg;
    // Width of the operands of a leaf cell
    localparam int unsigned XW_LEAF_W = 2;

    // True when w is a power of two and at least the leaf width
    function automatic bit xw_width_ok(input int unsigned w);
        return (w >= XW_LEAF_W) && ((w & (w - 1)) == 0);
    endfunction
endpackage

// File: rtl/xw_cell2.sv
// Module: 2x2 leaf multiplier built from bitwise crosswise terms.
// The vertical terms are a0*b0 and a1*b1. The crosswise pair is a1*b0 and a0*b1.
// Assumes nothing beyond 2-bit unsigned operands; purely combinational.
module xw_cell2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic v_lo, v_hi, x_0, x_1, x_carry;

    // Form the vertical and crosswise bit products
    always_comb begin
        v_lo    = a[0] & b[0];
        v_hi    = a[1] & b[1];
        x_0     = a[1] & b[0];
        x_1     = a[0] & b[1];
        x_carry = x_0 & x_1;
    end

    // Merge the terms into the 4-bit product
    always_comb begin
        p[0] = v_lo;
        p[1] = x_0 ^ x_1;
        p[2] = v_hi ^ x_carry;
        p[3] = v_hi & x_carry;
    end

    // R9: the leaf product is exact
    always_comb begin
        p_cell_exact_r9: assert (p == 4'(a) * 4'(b))
            else $error("leaf cell product wrong");
    end
endmodule

// File: rtl/xw_csa3.sv
// Module: carry-save stage that compresses three rows into a sum and a carry.
// The carry is returned unshifted; the caller weights it by two.
// Assumes the caller supplies rows of the same width; purely combinational.
module xw_csa3 #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] row_x,
    input  logic [W-1:0] row_y,
    input  logic [W-1:0] row_z,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] car_v
);
    // One full adder per bit position, with no carry between columns
    for (genvar k = 0; k < W; k++) begin : g_col
        always_comb begin
            sum_v[k] = row_x[k] ^ row_y[k] ^ row_z[k];
            car_v[k] = (row_x[k] & row_y[k]) | (row_z[k] & (row_x[k] ^ row_y[k]));
        end
    end

    // R7: sum plus twice carry keeps the value of the three rows
    always_comb begin
        p_csa_sum_r7: assert (({2'b00, sum_v} + {1'b0, car_v, 1'b0}) ==
                              ({2'b00, row_x} + {2'b00, row_y} + {2'b00, row_z}))
            else $error("carry-save stage lost value");
    end
endmodule

// File: rtl/xw_mul_node.sv
// Module: W x W unsigned multiplier built by the split-and-crosswise method.
// It recurses through itself down to 2x2 leaf cells. Above the leaf, it packs
// the vertical products into one row and adds the two crosswise rows
// through one carry-save stage and one carry-propagate add.
// Assumes W is a power of two of at least the leaf width; purely combinational.
module xw_mul_node
    import xw_mul_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned PW = 2 * W;

    if (W == XW_LEAF_W) begin : g_leaf
        xw_cell2 u_cell (
            .a (a),
            .b (b),
            .p (p)
        );
    end else begin : g_split
        localparam int unsigned H = W / 2;

        logic [W-1:0]  pr_ll, pr_hh, pr_hl, pr_lh;
        logic [PW-1:0] row_v, row_c1, row_c2, s_v, c_v;

        xw_mul_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(pr_ll));
        xw_mul_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(pr_hh));
        xw_mul_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(pr_hl));
        xw_mul_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(pr_lh));

        // Arrange the sub-products as three rows
        always_comb begin
            row_v  = {pr_hh, pr_ll};
            row_c1 = {{H{1'b0}}, pr_hl, {H{1'b0}}};
            row_c2 = {{H{1'b0}}, pr_lh, {H{1'b0}}};
        end

        xw_csa3 #(.W(PW)) u_csa (
            .row_x (row_v),
            .row_y (row_c1),
            .row_z (row_c2),
            .sum_v (s_v),
            .car_v (c_v)
        );

        // Final carry-propagate add of sum and weighted carry
        always_comb begin
            p = s_v + {c_v[PW-2:0], 1'b0};
        end

        // R1: each node returns its exact product
        always_comb begin
            p_node_exact_r1: assert (p == PW'(a) * PW'(b))
                else $error("node product wrong");
        end
    end
endmodule

// File: rtl/xw_mul32.sv
// Module: top-level 32x32 unsigned multiplier with a 64-bit product.
// It splits each operand into halves and forms four sub-products with
// recursive crosswise nodes. The sub-products are packed into three rows,
// reduced by one carry-save stage and added once.
// Assumes unsigned operands; no clock, no reset, no registers.
module xw_mul32
    import xw_mul_pkg::*;
#(
    parameter int unsigned OPW = 32
) (
    input  logic [OPW-1:0]   op_a,
    input  logic [OPW-1:0]   op_b,
    output logic [2*OPW-1:0] product
);
    localparam int unsigned HALF = OPW / 2;
    localparam int unsigned PW   = 2 * OPW;

    logic [OPW-1:0] sp_ll, sp_hh, sp_hl, sp_lh;
    logic [PW-1:0]  row_vert, row_cross_a, row_cross_b, csa_sum, csa_car;
    logic           cpa_cout;

    // Elaboration-time check of the operand width
    initial begin
        p_width_ok_r1: assert (xw_width_ok(OPW))
            else $error("OPW must be a power of two");
    end

    xw_mul_node #(.W(HALF)) u_vert_lo  (.a(op_a[HALF-1:0]),   .b(op_b[HALF-1:0]),   .p(sp_ll));
    xw_mul_node #(.W(HALF)) u_vert_hi  (.a(op_a[OPW-1:HALF]), .b(op_b[OPW-1:HALF]), .p(sp_hh));
    xw_mul_node #(.W(HALF)) u_cross_hl (.a(op_a[OPW-1:HALF]), .b(op_b[HALF-1:0]),   .p(sp_hl));
    xw_mul_node #(.W(HALF)) u_cross_lh (.a(op_a[HALF-1:0]),   .b(op_b[OPW-1:HALF]), .p(sp_lh));

    // Pack the vertical pair into one row and shift the crosswise rows
    always_comb begin
        row_vert    = {sp_hh, sp_ll};
        row_cross_a = {{HALF{1'b0}}, sp_hl, {HALF{1'b0}}};
        row_cross_b = {{HALF{1'b0}}, sp_lh, {HALF{1'b0}}};
    end

    xw_csa3 #(.W(PW)) u_csa (
        .row_x (row_vert),
        .row_y (row_cross_a),
        .row_z (row_cross_b),
        .sum_v (csa_sum),
        .car_v (csa_car)
    );

    // Single carry-propagate add; the carry out is kept only for checking
    always_comb begin
        {cpa_cout, product} = {1'b0, csa_sum} + {1'b0, csa_car[PW-2:0], 1'b0};
    end

    // Checks next to the final adder
    always_comb begin
        // R7: no carry leaves the top of the carry vector or the final add
        p_no_overflow_r7: assert (!cpa_cout && !csa_car[PW-1])
            else $error("carry lost above the top product bit");
        // R1: the full product is exact
        p_exact_r1: assert (product == PW'(op_a) * PW'(op_b))
            else $error("product wrong");
        // R2: a zero operand gives a zero product
        p_zero_r2: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("zero operand gave non-zero product");
    end
endmodule

// File: tb/xw_mul32_tb_top.sv
// Bench: fixed corner operands and seeded random pairs. Each result is
// compared with a shift-and-add reference computed by a bench function.
module xw_mul32_tb_top;
    localparam int unsigned OPW      = 32;
    localparam int unsigned PW       = 64;
    localparam time         CLK_HALF = 10ns;
    localparam int unsigned WD_LIMIT = 100000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [OPW-1:0] op_a = '0;
    logic [OPW-1:0] op_b = '0;
    logic [PW-1:0]  product;
    int unsigned    n_checks = 0;
    int unsigned    n_fail = 0;
    bit             done = 1'b0;

    xw_mul32 #(.OPW(OPW)) dut_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    // 50 MHz clock used only to pace the stimulus
    always #(CLK_HALF) clk = ~clk;

    // Shift-and-add reference product
    function automatic logic [PW-1:0] ref_mul(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
        logic [PW-1:0] acc = '0;
        for (int k = 0; k < OPW; k++)
            if (y[k]) acc = acc + (PW'(x) << k);
        return acc;
    endfunction

    // Compare the output against an expected value
    task automatic check(input string req, input logic [PW-1:0] exp_v);
        n_checks++;
        if (product !== exp_v) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, product, exp_v);
        end
    endtask

    // Drive operands away from the edge and sample after they settle
    task automatic apply(input logic [OPW-1:0] x, input logic [OPW-1:0] y, input string req);
        @(negedge clk);
        op_a = x;
        op_b = y;
        #1;
        check(req, ref_mul(x, y));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: zero operands give zero (R2)
        @(negedge clk);
        #1;
        check("R2 reset", 64'd0);

        // R2: a zero operand
        apply(32'h0, 32'hDEADBEEF, "R2");
        apply(32'hFFFFFFFF, 32'h0, "R2");
        // R3: identity
        apply(32'h1, 32'h89ABCDEF, "R3");
        apply(32'hFEDCBA98, 32'h1, "R3");
        // R4: all-ones extreme
        @(negedge clk);
        op_a = '1;
        op_b = '1;
        #1;
        check("R4", 64'hFFFFFFFE00000001);
        // R5: single-bit operands
        for (int i = 0; i < OPW; i += 3)
            for (int j = 0; j < OPW; j += 5) begin
                @(negedge clk);
                op_a = 32'd1 << i;
                op_b = 32'd1 << j;
                #1;
                check("R5", 64'd1 << (i + j));
            end
        // R6: operands non-zero in one half only
        @(negedge clk); op_a = 32'h00010000; op_b = 32'h00010000; #1; check("R6 hh", 64'h0000000100000000);
        @(negedge clk); op_a = 32'h0000FFFF; op_b = 32'h0000FFFF; #1; check("R6 ll", 64'h00000000FFFE0001);
        @(negedge clk); op_a = 32'hFFFF0000; op_b = 32'h0000FFFF; #1; check("R6 hl", 64'h0000FFFE00010000);
        @(negedge clk); op_a = 32'h0000FFFF; op_b = 32'hFFFF0000; #1; check("R6 lh", 64'h0000FFFE00010000);
        // R7: dense rows that chain carries through the seams
        apply(32'hFFFF0000, 32'hFFFFFFFF, "R7");
        apply(32'hAAAAAAAA, 32'h55555555, "R7");
        apply(32'hFFFFFFFF, 32'h80000001, "R7");
        apply(32'h0001FFFF, 32'hFFFF0001, "R7");
        // R9: the small-number table
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++) begin
                @(negedge clk);
                op_a = 32'(x);
                op_b = 32'(y);
                #1;
                check("R9", 64'(x * y));
            end
        // R8: the output follows the inputs without any clock edge
        @(posedge clk);
        #2;
        op_a = 32'h12345678;
        op_b = 32'h9ABCDEF0;
        #1;
        check("R8", ref_mul(32'h12345678, 32'h9ABCDEF0));
        // R1: seeded random pairs, some with a half forced to all-ones or zero
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [OPW-1:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            case (n % 5)
                1: ra[15:0]  = 16'hFFFF;
                2: rb[31:16] = 16'hFFFF;
                3: ra[31:16] = 16'h0000;
                default: ;
            endcase
            apply(ra, rb, "R1");
        end
        done = 1'b1;
    end

    // Watchdog, then the summary line
    initial begin
        fork
            wait (done);
            begin
                repeat (WD_LIMIT) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule